// File: doc/BRIEF.md
# I2C Address Bit-Inversion Translator

This block sits in the data line of an I2C segment, between an upstream master and a downstream group of slaves. After every START it inverts selected bits of the seven-bit slave address on the fly. Each address bit is XORed with a bit from a configured pattern, so one physical slave can answer at a different bus address. The read/write bit, the acknowledge bit and all data bytes pass through unchanged. The block does not buffer or re-time the byte. It changes the inversion bit a few system clocks after each SCL falling edge, while SCL is still low. The downstream line therefore only moves in the low phase of SCL.

The block also deals with bus conditions that the inversion could corrupt. A START or a STOP that arrives in the middle of the address byte is repaired. If the downstream side would see a START in place of a STOP, the block disconnects the downstream line, holds it low for a while and then releases it, which gives the slaves a clean STOP. If SCL stops toggling during the address byte, a timeout ends the translation. A pass-through input overrides everything and connects the line straight through.

Top module: `i2c_addr_xor`

## Requirements
- R1: The inversion pattern is `{xor_cfg[6:0], 1'b0}`. Address bit k (k = 0 is the first bit after START, MSB first) leaves as `sda_in XOR pattern[7-k]`, so bit k = 7 (read/write) is never inverted.
- R2: A START is SDA falling while SCL is high. From the START until the first SCL falling edge, `sda_out` follows `sda_in` unchanged. Inversion for the next bit takes effect `ADV_DLY` clocks after each synchronized SCL falling edge.
- R3: After the eighth address bit, the acknowledge bit and the data bits pass through unchanged.
- R4: After reset, `path_on` is 1 and `sda_out` follows the idle-high `sda_in`.
- R5: A START received after the first address bit has begun stops the translation. SDA then passes unchanged, and further STARTs do not begin translation, until a STOP is seen. The next START after that translates normally.
- R6: A STOP (SDA rising while SCL is high) received during the address byte while the current inversion bit is 0 ends the translation without disconnecting. Later bits pass unchanged until a new START.
- R7: A STOP received during the address byte while the current inversion bit is 1 drops `path_on` to 0 and holds `sda_out` at 0 for `RPR_DLY` clocks. The block then releases `sda_out` to 1 and raises `path_on` again.
- R8: If SCL does not change for `TMO_TICKS` pulses of `tick` during the address byte, translation ends and SDA passes unchanged.
- R9: While `pass_req` is 1, `path_on` is 1 and `sda_out` follows `sda_in` with no inversion. Any translation in progress ends, and a START during that time does not begin one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Upstream SCL level |
| sda_in | input | 1 | Upstream SDA level |
| xor_cfg | input | 7 | Address inversion pattern, bit 6 applies to the first address bit |
| pass_req | input | 1 | Forces a straight connection with no inversion |
| tick | input | 1 | Timebase pulse used by the stuck-clock timeout |
| sda_out | output | 1 | Downstream SDA level (1 = released) |
| path_on | output | 1 | 1 while upstream and downstream SDA are connected |

## Verification
An internal state that is wrong appears at `sda_out` at the next SCL-high sample. A bit counter that is off by one shifts the pattern: a bit is inverted on the wrong address bit, the read/write bit gets inverted, or the acknowledge bit gets inverted. All of these show up within one byte when the full range of patterns is swept. A sequencer that enters the wrong state after a misplaced START or STOP shows up in one of three ways: `path_on` drops when it should not, the line is held low for a wrong length, or the bits that follow are inverted when they should pass unchanged. Each of these is visible within a few SCL periods.

// File: rtl/i2c_addr_xor.sv
module i2c_addr_xor #(
  parameter int ADV_DLY   = 8,
  parameter int RPR_DLY   = 32,
  parameter int TMO_TICKS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [6:0] xor_cfg,
  input  logic       pass_req,
  input  logic       tick,
  output logic       sda_out,
  output logic       path_on
);
  localparam int DW = $clog2(ADV_DLY + 1);
  localparam int RW = $clog2(RPR_DLY + 1);
  localparam int TW = $clog2(TMO_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_HOLD, ST_FIX} st_t;

  st_t         st;
  logic [1:0]  scl_sy, sda_sy;
  logic        scl_q, sda_q;
  logic [3:0]  bit_n;
  logic        pend;
  logic [DW-1:0] dcnt;
  logic [RW-1:0] rcnt;
  logic [TW-1:0] tcnt;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_fall  = scl_q & ~scl_s;
  wire scl_edge  = scl_q ^ scl_s;
  wire tmo_hit   = tick && (tcnt == TW'(TMO_TICKS - 1));

  wire [7:0] pat = {xor_cfg, 1'b0};
  wire [2:0] sel = 3'(4'd8 - bit_n);
  wire active = (st == ST_ADDR) && (bit_n != 4'd0) && pat[sel];

  assign path_on = pass_req | (st != ST_FIX);
  assign sda_out = pass_req ? sda_s : (st == ST_FIX) ? 1'b0 : (sda_s ^ active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      bit_n <= '0;
      pend  <= 1'b0;
      dcnt  <= '0;
      rcnt  <= '0;
      tcnt  <= '0;
    end else if (pass_req) begin
      st    <= ST_IDLE;
      bit_n <= '0;
      pend  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_det) begin
            st    <= ST_ADDR;
            bit_n <= '0;
            pend  <= 1'b0;
            tcnt  <= '0;
          end
        end
        ST_ADDR: begin
          if (scl_edge)  tcnt <= '0;
          else if (tick) tcnt <= tcnt + 1'b1;
          if (stop_det) begin
            st   <= active ? ST_FIX : ST_IDLE;
            rcnt <= '0;
            pend <= 1'b0;
          end else if (start_det) begin
            if (bit_n != 4'd0) st <= ST_HOLD;
            bit_n <= '0;
            pend  <= 1'b0;
          end else if (tmo_hit) begin
            st   <= ST_IDLE;
            pend <= 1'b0;
          end else if (scl_fall) begin
            pend <= 1'b1;
            dcnt <= '0;
          end else if (pend) begin
            if (dcnt == DW'(ADV_DLY - 1)) begin
              pend <= 1'b0;
              if (bit_n == 4'd8) st <= ST_IDLE;
              else               bit_n <= bit_n + 1'b1;
            end else begin
              dcnt <= dcnt + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (stop_det) st <= ST_IDLE;
        end
        ST_FIX: begin
          if (rcnt == RW'(RPR_DLY - 1)) st <= ST_IDLE;
          else                          rcnt <= rcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module i2c_addr_xor_chk #(
  parameter int RPR_DLY = 32
) (
  input logic clk,
  input logic rst_n,
  input logic pass_req,
  input logic sda_out,
  input logic path_on
);
  int offc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        offc <= 0;
    else if (!path_on) offc <= offc + 1;
    else               offc <= 0;
  end

  a_r7_bounded_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
    offc <= RPR_DLY + 1);
  a_r7_disconnect_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(path_on) |-> !$past(sda_out));
  a_r7_reconnect_released: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(path_on) && !pass_req) |-> sda_out);
  a_r9_release_connected: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pass_req) |-> path_on);
endmodule

bind i2c_addr_xor i2c_addr_xor_chk #(.RPR_DLY(RPR_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .pass_req(pass_req), .sda_out(sda_out), .path_on(path_on));

// File: tb/i2c_addr_xor_tb.sv
module i2c_addr_xor_tb;
  localparam int CLK_P = 10;
  localparam int ADV = 4;
  localparam int RPR = 16;
  localparam int TMO = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, pass = 1'b0, tick = 1'b0;
  logic [6:0] cfg = '0;
  logic sda_out, path_on;
  int checks = 0, errors = 0, tc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) begin
    tc++;
    tick = (tc % 4 == 0);
  end

  i2c_addr_xor #(.ADV_DLY(ADV), .RPR_DLY(RPR), .TMO_TICKS(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .xor_cfg(cfg),
    .pass_req(pass), .tick(tick), .sda_out(sda_out), .path_on(path_on));

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_start(input bit verify);
    sda = 1'b1; w(10);
    scl = 1'b1; w(10);
    sda = 1'b0; w(10);
    if (verify) chk("R2 start untouched", sda_out, 1'b0);
    scl = 1'b0; w(10);
  endtask

  task automatic do_stop();
    sda = 1'b0; w(10);
    scl = 1'b1; w(10);
    sda = 1'b1; w(10);
  endtask

  task automatic send_bit(input logic b, input logic exp, input string tag);
    sda = b; w(10);
    scl = 1'b1; w(10);
    chk(tag, sda_out, exp);
    w(10);
    scl = 1'b0; w(10);
  endtask

  task automatic xfer(input logic [6:0] c, input logic [7:0] addr);
    logic [7:0] pat;
    cfg = c;
    pat = {c, 1'b0};
    do_start(1);
    for (int k = 0; k < 8; k++)
      send_bit(addr[7-k], addr[7-k] ^ pat[7-k], "R1 address bit");
    send_bit(1'b1, 1'b1, "R3 ack");
    send_bit(~addr[0], ~addr[0], "R3 data");
    send_bit(addr[0], addr[0], "R3 data");
    do_stop();
  endtask

  initial begin
    w(3); rst_n = 1'b1; w(5);
    chk("R4 path_on", path_on, 1'b1);
    chk("R4 sda_out", sda_out, 1'b1);

    for (int c = 0; c < 128; c++)
      xfer(7'(c), 8'((c * 73 + 5) & 255));

    // R5: START after first address bit
    cfg = 7'h7F;
    do_start(1);
    send_bit(1'b1, 1'b0, "R5 pre");
    sda = 1'b1; w(10); scl = 1'b1; w(10); sda = 1'b0; w(10); scl = 1'b0; w(10);
    send_bit(1'b1, 1'b1, "R5 hold untranslated");
    send_bit(1'b0, 1'b0, "R5 hold untranslated");
    do_start(0);
    send_bit(1'b1, 1'b1, "R5 start ignored in hold");
    do_stop();
    xfer(7'h7F, 8'hA5);

    // R6: STOP while inversion bit is 0
    cfg = 7'h00;
    do_start(1);
    send_bit(1'b1, 1'b1, "R6 pre");
    send_bit(1'b0, 1'b0, "R6 pre");
    sda = 1'b0; w(10); scl = 1'b1; w(10); sda = 1'b1; w(6);
    chk("R6 stays connected", path_on, 1'b1);
    w(20);
    chk("R6 stays connected", path_on, 1'b1);
    chk("R6 line released", sda_out, 1'b1);
    cfg = 7'h7F;
    scl = 1'b0; w(10);
    send_bit(1'b0, 1'b0, "R6 aborted untranslated");
    do_stop();

    // R7: STOP while inversion bit is 1
    cfg = 7'h7F;
    do_start(1);
    send_bit(1'b1, 1'b0, "R7 pre");
    sda = 1'b0; w(10);
    chk("R7 inverted before stop", sda_out, 1'b1);
    scl = 1'b1; w(10);
    sda = 1'b1; w(6);
    chk("R7 disconnect", path_on, 1'b0);
    chk("R7 held low", sda_out, 1'b0);
    w(6);
    chk("R7 disconnect", path_on, 1'b0);
    chk("R7 held low", sda_out, 1'b0);
    w(18);
    chk("R7 reconnect", path_on, 1'b1);
    chk("R7 released", sda_out, 1'b1);
    w(10);
    xfer(7'h35, 8'h6C);

    // R8: stuck SCL timeout
    cfg = 7'h7F;
    do_start(1);
    send_bit(1'b1, 1'b0, "R8 pre");
    sda = 1'b0; w(5);
    chk("R8 still translating", sda_out, 1'b1);
    w(45);
    chk("R8 timed out", sda_out, 1'b0);
    sda = 1'b1; w(3);
    chk("R8 timed out", sda_out, 1'b1);
    do_stop();

    // R9: pass-through
    cfg = 7'h7F;
    do_start(1);
    send_bit(1'b1, 1'b0, "R9 pre");
    chk("R9 pre inverted", sda_out, 1'b0);
    pass = 1'b1; w(1);
    chk("R9 immediate", sda_out, 1'b1);
    chk("R9 connected", path_on, 1'b1);
    send_bit(1'b0, 1'b0, "R9 straight");
    do_start(0);
    send_bit(1'b1, 1'b1, "R9 no translation");
    send_bit(1'b0, 1'b0, "R9 no translation");
    do_stop();
    pass = 1'b0; w(5);
    xfer(7'h4B, 8'h9E);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule